// File: doc/BRIEF.md
# Handshaked byte-serial command engine

This block is the device side of a byte-at-a-time command link. A host moves bytes through an 8-bit shift-register port. It paces every byte with two active-low lines held in a small port register: a request line that the host drives, and an acknowledge line that the host and the engine share. The engine reacts only when that register changes. It pulls acknowledge low to take a byte and raises it again when the host lets go.

Each transaction runs through three phases. A command byte arrives first. Argument bytes follow. Reply bytes then go back to the host. The engine looks up each command's argument and reply lengths in a computed 256-entry table. It stores the arguments and pulses a dispatch strobe to an external executor, which reads the arguments and fills a reply buffer. The engine then streams that buffer to the host. A table entry may instead mark a length as variable. In that case the count travels on the link itself: the host sends an argument count, or the engine sends the reply size as the first reply byte.

Top module: `cmd_serial_engine`

## Requirements
- R1: After reset the handshake register reads 2'b11 (bit 1 = request, bit 0 = acknowledge, both active low) and `byte_done_o`, `err_o` and `disp_o` are low.
- R2: A host write that leaves the register equal to the value the engine last saw causes no action: no `byte_done_o`, no `err_o`, no change of phase.
- R3: A change to 2'b01 (request low, acknowledge high) is a request. One cycle after the write takes effect, the engine has driven acknowledge low (register 2'b00), handled one byte and pulsed `byte_done_o`.
- R4: A change to 2'b10 (request high, acknowledge low) is a release. The engine drives acknowledge high again (register 2'b11) and handles no byte.
- R5: A change to 2'b00 pulses `err_o` and is otherwise ignored. No byte is taken and the phase is kept.
- R6: In idle the received byte is the command code c. Its fixed argument length is c[2:0] and its fixed reply length is c[5:3]. The value 7 in either field marks that length as variable. Codes with c[7]=0 are known; codes with c[7]=1 are unknown.
- R7: With a variable argument length, the first byte after the command is the argument count. The bytes that follow are the arguments.
- R8: With a variable reply length, the first reply byte is the reply size. For a known command the size is `rsp_size_i`, sampled when that byte is sent.
- R9: The idle and command phases require `sr_dir_i`=1 (host to device). The reply phase requires `sr_dir_i`=0. On a mismatch the engine still pulls acknowledge low and pulses `err_o`, but it drops the byte, holds its position and raises no `byte_done_o`.
- R10: When the argument count reaches the expected length, `disp_o` pulses with `disp_cmd_o` and `disp_argc_o` and the reply phase begins. When the reply position reaches the reply length, the engine returns to idle. Both steps also complete at once for zero lengths.
- R11: An unknown command with a fixed reply length returns that many 0x00 bytes. With a variable reply length it returns only a size byte of 0.
- R12: Arguments beyond `ARG_DEPTH` are counted but not stored. The first `ARG_DEPTH` arguments stay readable at `arg_raddr_i`.
- R13: Reply byte i of a known command is reply-buffer entry i, as written by the executor through `rsp_we_i` before that byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_wr_i | input | 1 | Host write strobe for the handshake register |
| hs_wdata_i | input | 2 | Value written by the host: {request_n, acknowledge_n} |
| hs_port_o | output | 2 | Current handshake register |
| sr_dir_i | input | 1 | Shift-register direction, 1 = host to device |
| sr_rx_i | input | 8 | Byte shifted in by the host |
| sr_tx_o | output | 8 | Byte offered to the host |
| byte_done_o | output | 1 | Pulse after each byte handled |
| err_o | output | 1 | Pulse on an invalid handshake or a direction mismatch |
| disp_o | output | 1 | Dispatch strobe to the executor |
| disp_cmd_o | output | 8 | Command code being dispatched |
| disp_argc_o | output | 8 | Number of argument bytes received |
| arg_raddr_i | input | $clog2(ARG_DEPTH) | Executor read address into the argument store |
| arg_rdata_o | output | 8 | Argument byte at that address |
| rsp_we_i | input | 1 | Executor write strobe for the reply buffer |
| rsp_waddr_i | input | $clog2(RSP_DEPTH) | Reply-buffer write address |
| rsp_wdata_i | input | 8 | Reply-buffer write data |
| rsp_size_i | input | 8 | Reply size for known commands with a variable reply length |

## Verification
A single request handshake can take a command byte, dispatch it and return the engine to idle. This happens for every code whose argument and reply fields are both zero. It also happens for a variable-length command that is given a count of zero and has a zero-length reply. The bench sweeps all 256 codes, so every combination of fixed, variable, zero and nonzero length occurs. After the relevant byte it judges `disp_o`, `disp_argc_o` and the interpretation of the next byte: the next byte must be read as a new command, not as an argument or a reply slot. The other case where two events coincide is a direction mismatch: `err_o` rises while acknowledge still drops. The bench provokes this in both the command phase and the reply phase. It then checks that the next correctly-directed byte is taken as if the rejected one had never arrived.

// File: rtl/cmd_eng_pkg.sv
package cmd_eng_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CMD  = 2'd1,
    PH_RSP  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    HS_BAD  = 2'b00,
    HS_REQ  = 2'b01,
    HS_REL  = 2'b10,
    HS_IDLE = 2'b11
  } hs_e;

  typedef struct packed {
    logic       var_n;
    logic [7:0] n;
  } len_t;

  typedef struct packed {
    logic known;
    len_t arg;
    len_t rsp;
  } cmd_info_t;

  // computed command table: field value 7 marks a variable length
  function automatic cmd_info_t cmd_lookup(input logic [7:0] c);
    cmd_info_t r;
    r.known     = ~c[7];
    r.arg.var_n = (c[2:0] == 3'd7);
    r.arg.n     = r.arg.var_n ? 8'd0 : {5'd0, c[2:0]};
    r.rsp.var_n = (c[5:3] == 3'd7);
    r.rsp.n     = r.rsp.var_n ? 8'd0 : {5'd0, c[5:3]};
    return r;
  endfunction

endpackage

// File: rtl/hs_monitor.sv
module hs_monitor
  import cmd_eng_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  output logic       evt_o,
  output hs_e        kind_o,
  output logic [1:0] port_o
);

  logic [1:0] hs_q, last_q;

  assign evt_o  = (hs_q != last_q);
  assign kind_o = hs_e'(hs_q);
  assign port_o = hs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q   <= 2'b11;
      last_q <= 2'b11;
    end else begin
      if (wr_i)                           hs_q    <= wdata_i;
      else if (evt_o && kind_o == HS_REQ) hs_q[0] <= 1'b0;
      else if (evt_o && kind_o == HS_REL) hs_q[0] <= 1'b1;
      if (evt_o) begin
        unique case (kind_o)
          HS_REQ:  last_q <= {hs_q[1], 1'b0};
          HS_REL:  last_q <= {hs_q[1], 1'b1};
          default: last_q <= hs_q;
        endcase
      end
    end
  end

  assert_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && kind_o == HS_REL && !wr_i) |=> (port_o == 2'b11));

  assert_ack_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && kind_o == HS_REQ && !wr_i) |=> (port_o == 2'b00));

endmodule

// File: rtl/byte_store.sv
module byte_store #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);

  logic [7:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[i] <= 8'h00;
      else if (we_i && waddr_i == AW'(i))        mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/cmd_serial_engine.sv
module cmd_serial_engine
  import cmd_eng_pkg::*;
#(
  parameter int ARG_DEPTH = 16,
  parameter int RSP_DEPTH = 32,
  localparam int AAW = $clog2(ARG_DEPTH),
  localparam int RAW = $clog2(RSP_DEPTH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           hs_wr_i,
  input  logic [1:0]     hs_wdata_i,
  output logic [1:0]     hs_port_o,
  input  logic           sr_dir_i,
  input  logic [7:0]     sr_rx_i,
  output logic [7:0]     sr_tx_o,
  output logic           byte_done_o,
  output logic           err_o,
  output logic           disp_o,
  output logic [7:0]     disp_cmd_o,
  output logic [7:0]     disp_argc_o,
  input  logic [AAW-1:0] arg_raddr_i,
  output logic [7:0]     arg_rdata_o,
  input  logic           rsp_we_i,
  input  logic [RAW-1:0] rsp_waddr_i,
  input  logic [7:0]     rsp_wdata_i,
  input  logic [7:0]     rsp_size_i
);

  logic evt;
  hs_e  kind;

  hs_monitor u_hs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (hs_wr_i),
    .wdata_i (hs_wdata_i),
    .evt_o   (evt),
    .kind_o  (kind),
    .port_o  (hs_port_o)
  );

  phase_e     phase_q, phase_n;
  logic [7:0] cmd_q, cmd_n;
  logic       known_q, known_n;
  logic [7:0] need_q, need_n, cnt_q, cnt_n;
  logic       need_ok_q, need_ok_n;
  logic [7:0] rlen_q, rlen_n, rpos_q, rpos_n;
  logic       rlen_ok_q, rlen_ok_n;
  logic [7:0] tx_q, tx_n;
  logic       done_q, done_n, err_q, err_n, disp_q, disp_n;
  logic       arg_we;
  logic [7:0] rsp_rdata;
  cmd_info_t  info;

  byte_store #(.DEPTH(ARG_DEPTH)) u_args (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (arg_we),
    .waddr_i (cnt_q[AAW-1:0]),
    .wdata_i (sr_rx_i),
    .raddr_i (arg_raddr_i),
    .rdata_o (arg_rdata_o)
  );

  byte_store #(.DEPTH(RSP_DEPTH)) u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rsp_we_i),
    .waddr_i (rsp_waddr_i),
    .wdata_i (rsp_wdata_i),
    .raddr_i (rpos_q[RAW-1:0]),
    .rdata_o (rsp_rdata)
  );

  assign info = cmd_lookup(sr_rx_i);

  always_comb begin
    phase_n = phase_q;  cmd_n = cmd_q;  known_n = known_q;
    need_n = need_q;    need_ok_n = need_ok_q;  cnt_n = cnt_q;
    rlen_n = rlen_q;    rlen_ok_n = rlen_ok_q;  rpos_n = rpos_q;
    tx_n = tx_q;
    done_n = 1'b0;  err_n = 1'b0;  disp_n = 1'b0;  arg_we = 1'b0;
    if (evt && kind == HS_BAD) err_n = 1'b1;
    if (evt && kind == HS_REQ) begin
      unique case (phase_q)
        PH_IDLE: begin
          if (!sr_dir_i) err_n = 1'b1;
          else begin
            done_n    = 1'b1;
            cmd_n     = sr_rx_i;
            known_n   = info.known;
            need_n    = info.arg.n;
            need_ok_n = ~info.arg.var_n;
            rlen_n    = info.rsp.n;
            rlen_ok_n = ~info.rsp.var_n;
            cnt_n     = 8'd0;
            rpos_n    = 8'd0;
            phase_n   = PH_CMD;
          end
        end
        PH_CMD: begin
          if (!sr_dir_i) err_n = 1'b1;
          else begin
            done_n = 1'b1;
            if (!need_ok_q) begin
              need_n    = sr_rx_i;
              need_ok_n = 1'b1;
            end else begin
              arg_we = (int'(cnt_q) < ARG_DEPTH);
              cnt_n  = cnt_q + 8'd1;
            end
          end
        end
        PH_RSP: begin
          if (sr_dir_i) err_n = 1'b1;
          else begin
            done_n = 1'b1;
            if (!rlen_ok_q) begin
              tx_n      = known_q ? rsp_size_i : 8'd0;
              rlen_n    = tx_n;
              rlen_ok_n = 1'b1;
            end else if (rpos_q < rlen_q) begin
              tx_n   = (known_q && int'(rpos_q) < RSP_DEPTH) ? rsp_rdata : 8'd0;
              rpos_n = rpos_q + 8'd1;
            end
          end
        end
        default: phase_n = PH_IDLE;
      endcase
      // completion chains within one handshake
      if (phase_n == PH_CMD && need_ok_n && cnt_n == need_n) begin
        disp_n  = 1'b1;
        phase_n = PH_RSP;
      end
      if (phase_n == PH_RSP && rlen_ok_n && rpos_n == rlen_n) phase_n = PH_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;  cmd_q <= 8'd0;  known_q <= 1'b0;
      need_q <= 8'd0;  need_ok_q <= 1'b1;  cnt_q <= 8'd0;
      rlen_q <= 8'd0;  rlen_ok_q <= 1'b1;  rpos_q <= 8'd0;
      tx_q <= 8'd0;  done_q <= 1'b0;  err_q <= 1'b0;  disp_q <= 1'b0;
    end else begin
      phase_q <= phase_n;  cmd_q <= cmd_n;  known_q <= known_n;
      need_q <= need_n;  need_ok_q <= need_ok_n;  cnt_q <= cnt_n;
      rlen_q <= rlen_n;  rlen_ok_q <= rlen_ok_n;  rpos_q <= rpos_n;
      tx_q <= tx_n;  done_q <= done_n;  err_q <= err_n;  disp_q <= disp_n;
    end
  end

  assign sr_tx_o     = tx_q;
  assign byte_done_o = done_q;
  assign err_o       = err_q;
  assign disp_o      = disp_q;
  assign disp_cmd_o  = cmd_q;
  assign disp_argc_o = cnt_q;

  assert_disp_on_byte_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_o |-> byte_done_o);

  assert_err_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_o && byte_done_o));

  assert_arg_bound_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CMD && need_ok_q) |-> (cnt_q < need_q));

  assert_rsp_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RSP && rlen_ok_q) |-> (rpos_q < rlen_q));

  assert_no_evt_no_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt) |=> (!byte_done_o && !disp_o));

endmodule

// File: tb/cmd_serial_engine_tb.sv
module cmd_serial_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ARG_DEPTH  = 16;
  localparam int RSP_DEPTH  = 32;
  localparam int AAW = $clog2(ARG_DEPTH);
  localparam int RAW = $clog2(RSP_DEPTH);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           hs_wr = 1'b0;
  logic [1:0]     hs_wdata = 2'b11;
  logic [1:0]     hs_port;
  logic           sr_dir = 1'b1;
  logic [7:0]     sr_rx = 8'd0;
  logic [7:0]     sr_tx;
  logic           byte_done, err, disp;
  logic [7:0]     disp_cmd, disp_argc;
  logic [AAW-1:0] arg_raddr = '0;
  logic [7:0]     arg_rdata;
  logic           rsp_we = 1'b0;
  logic [RAW-1:0] rsp_waddr = '0;
  logic [7:0]     rsp_wdata = 8'd0;
  logic [7:0]     rsp_size = 8'd0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_serial_engine #(.ARG_DEPTH(ARG_DEPTH), .RSP_DEPTH(RSP_DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .hs_wr_i(hs_wr), .hs_wdata_i(hs_wdata), .hs_port_o(hs_port),
    .sr_dir_i(sr_dir), .sr_rx_i(sr_rx), .sr_tx_o(sr_tx),
    .byte_done_o(byte_done), .err_o(err), .disp_o(disp),
    .disp_cmd_o(disp_cmd), .disp_argc_o(disp_argc),
    .arg_raddr_i(arg_raddr), .arg_rdata_o(arg_rdata),
    .rsp_we_i(rsp_we), .rsp_waddr_i(rsp_waddr), .rsp_wdata_i(rsp_wdata),
    .rsp_size_i(rsp_size)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] arg_pat(input logic [7:0] c, input int j);
    return c + 8'(j * 3) + 8'd1;
  endfunction

  function automatic logic [7:0] rsp_pat(input logic [7:0] c, input int i);
    return c ^ 8'(i * 29) ^ 8'h5A;
  endfunction

  task automatic hs_write(input logic [1:0] v);
    @(negedge clk);
    hs_wr = 1'b1;
    hs_wdata = v;
    @(negedge clk);
    hs_wr = 1'b0;
    @(negedge clk);
  endtask

  // one request; outputs sampled one cycle after the register took the write
  task automatic xfer(input logic [7:0] b, input logic dir,
                      output logic [7:0] tx, output logic dn, output logic dp, output logic er);
    @(negedge clk);
    sr_rx = b;
    sr_dir = dir;
    hs_wr = 1'b1;
    hs_wdata = 2'b01;
    @(negedge clk);
    hs_wr = 1'b0;
    @(negedge clk);
    tx = sr_tx; dn = byte_done; dp = disp; er = err;
    chk(hs_port == 2'b00, "R3 ack low", hs_port, 0);
  endtask

  task automatic release_hs();
    hs_write(2'b10);
    chk(hs_port == 2'b11, "R4 ack high", hs_port, 3);
    chk(!byte_done && !err, "R4 no byte", byte_done, 0);
  endtask

  task automatic fill_rsp(input logic [7:0] c, input logic [7:0] sz);
    for (int i = 0; i < RSP_DEPTH; i++) begin
      @(negedge clk);
      rsp_we = 1'b1;
      rsp_waddr = RAW'(i);
      rsp_wdata = rsp_pat(c, i);
    end
    @(negedge clk);
    rsp_we = 1'b0;
    rsp_size = sz;
  endtask

  task automatic run_cmd(input logic [7:0] c, input int argcnt, input bit inject);
    logic [7:0] tx;
    logic dn, dp, er;
    bit av, rv, known;
    int an, rn, len, nstore;
    an = int'(c[2:0]); rn = int'(c[5:3]);
    av = (an == 7); rv = (rn == 7); known = !c[7];
    if (!av) argcnt = an;
    xfer(c, 1'b1, tx, dn, dp, er);
    chk(dn && !er, "R3 cmd byte done", dn, 1);
    chk(dp == (!av && argcnt == 0), "R10 R6 dispatch on cmd byte", dp, !av && argcnt == 0);
    release_hs();
    if (inject) begin
      // invalid handshake and no-change write in command phase
      hs_write(2'b00);
      chk(err && !byte_done, "R5 both low flagged", err, 1);
      hs_write(2'b00);
      chk(!err && !byte_done, "R2 unchanged write ignored", err, 0);
      hs_write(2'b11);
      chk(!err && !byte_done, "R2 idle write no byte", byte_done, 0);
      xfer(8'hEE, 1'b0, tx, dn, dp, er);
      chk(er && !dn && !dp, "R9 cmd dir mismatch", er, 1);
      release_hs();
    end
    if (av) begin
      xfer(8'(argcnt), 1'b1, tx, dn, dp, er);
      chk(dn, "R7 count byte done", dn, 1);
      chk(dp == (argcnt == 0), "R7 R10 dispatch on zero count", dp, argcnt == 0);
      release_hs();
    end
    for (int j = 0; j < argcnt; j++) begin
      xfer(arg_pat(c, j), 1'b1, tx, dn, dp, er);
      chk(dn && !er, "R3 arg byte done", dn, 1);
      chk(dp == (j == argcnt - 1), "R10 dispatch at last arg", dp, j == argcnt - 1);
      release_hs();
    end
    chk(disp_cmd == c, "R10 dispatched code", disp_cmd, c);
    chk(int'(disp_argc) == argcnt, "R10 R7 argument count", disp_argc, argcnt);
    nstore = (argcnt < ARG_DEPTH) ? argcnt : ARG_DEPTH;
    for (int j = 0; j < nstore; j++) begin
      arg_raddr = AAW'(j);
      #1;
      chk(arg_rdata == arg_pat(c, j), "R12 R7 stored argument", arg_rdata, arg_pat(c, j));
    end
    fill_rsp(c, 8'(int'(c) % 6));
    len = rv ? (known ? int'(c) % 6 : 0) : rn;
    if (inject) begin
      xfer(8'h00, 1'b1, tx, dn, dp, er);
      chk(er && !dn, "R9 reply dir mismatch", er, 1);
      release_hs();
    end
    if (rv) begin
      xfer(8'h00, 1'b0, tx, dn, dp, er);
      chk(dn && int'(tx) == len, known ? "R8 reply size byte" : "R11 unknown size zero", tx, len);
      release_hs();
    end
    for (int i = 0; i < len; i++) begin
      xfer(8'h00, 1'b0, tx, dn, dp, er);
      if (known) chk(dn && tx == rsp_pat(c, i), "R13 reply byte", tx, rsp_pat(c, i));
      else       chk(dn && tx == 8'h00, "R11 unknown zero byte", tx, 0);
      release_hs();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(hs_port == 2'b11, "R1 reset port", hs_port, 3);
    chk(!byte_done && !err && !disp, "R1 reset pulses", {byte_done, err, disp}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    hs_write(2'b11);
    chk(!byte_done && !err, "R2 same value write", byte_done, 0);
    // full sweep of the command table
    for (int c = 0; c < 256; c++)
      run_cmd(8'(c), (c >> 3) % 5, 1'b0);
    // overflow of the argument store, then scripted error cases
    run_cmd(8'h07, 20, 1'b0);
    run_cmd(8'h3F, 3, 1'b1);
    run_cmd(8'h0A, 0, 1'b1);
    run_cmd(8'hBF, 2, 1'b1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule